// File: doc/BRIEF.md
# Boot Region Write Guard

This block keeps the protection state of the 16 KiB boot region of a 512K x 8 flash array. It filters program and erase requests against that state. A one-cycle enable pulse from the command sequencer sets the lock. From then on the block rejects every program request whose address falls in the boot region, and it marks the boot region as kept during a chip erase. Addresses outside the region are unaffected by the lock.

A parameter places the boot region at the low end or the high end of the array. While the product-identification mode is active, the block answers three read locations:
- the manufacturer code;
- the device code for the chosen placement;
- a lock-status byte.

The lock models non-volatile state, so only reset clears it. Decoding of the command sequences and the storage array sit outside this block.

Top module: `bootlock_guard`

## Requirements
- R1: After reset `locked_o` is 0.
- R2: A `lock_set_i` pulse sampled at a rising edge makes `locked_o` 1 from that edge on. It then stays 1 until reset, whatever further input arrives, including more `lock_set_i` pulses.
- R3: The boot region is 16 KiB. With `TOP_BOOT=1` it covers addresses 0x7C000 to 0x7FFFF. With `TOP_BOOT=0` it covers 0x00000 to 0x03FFF.
- R4: While locked, a request (`prog_req_i`=1) to an address in the boot region gives `prog_reject_o`=1 and `prog_ok_o`=0. Any other request gives `prog_ok_o`=1 and `prog_reject_o`=0. Both outputs respond in the same cycle as the request, with no register in the path.
- R5: While unlocked, every request gives `prog_ok_o`=1 at all addresses. With `prog_req_i`=0, both `prog_ok_o` and `prog_reject_o` are 0.
- R6: `erase_keep_o` is 1 exactly when the block is locked and `erase_addr_i` lies in the boot region. Otherwise it is 0, so that an erase clears the other 496 KiB.
- R7: With `id_mode_i`=1, address 0 reads 0x1F, and address 1 reads 0x13 when `TOP_BOOT=0` or 0x12 when `TOP_BOOT=1`. In both cases `id_hit_o`=1.
- R8: With `id_mode_i`=1, the lock-status location reads the lock state on bit 0 (1 means locked) and zeros on bits 7..1, with `id_hit_o`=1. That location is 0x00002 when `TOP_BOOT=0` and 0x7C002 when `TOP_BOOT=1`.
- R9: Any other address in ID mode, and any address when `id_mode_i`=0, gives `id_data_o`=0 and `id_hit_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; clears the lock |
| lock_set_i | input | 1 | One-cycle pulse that enables boot-region protection |
| prog_req_i | input | 1 | Program request valid |
| prog_addr_i | input | 19 | Byte address of the program request |
| prog_ok_o | output | 1 | Request may proceed |
| prog_reject_o | output | 1 | Request refused because the region is locked |
| erase_addr_i | input | 19 | Address being visited by a chip erase |
| erase_keep_o | output | 1 | Byte must be kept, not erased |
| id_mode_i | input | 1 | Product-identification mode active |
| id_addr_i | input | 19 | Read address while in ID mode |
| id_data_o | output | 8 | ID read data |
| id_hit_o | output | 1 | Address is one of the ID locations |
| locked_o | output | 1 | Current lock state |

## Verification
The region edges are the main target. The bench checks each side of 0x03FFF/0x04000 and 0x7BFFF/0x7C000 on both placements. A comparator that is off by one, or that tests the wrong end of the array, would reject a byte of main memory or let a byte of the boot region be programmed.

The bench also checks that the lock survives repeated enable pulses and long idle periods. A lock that toggles or decays would leave the region writable. It then checks that the lock-status byte follows the placement: a design with a fixed lock address would report lock state at the wrong location for one of the two variants. Finally, it sweeps the address space with the lock set and with it clear. A guard that ignores the lock state would reject programs before the lock is set, or keep bytes during an erase of an unlocked part.

// File: rtl/bootlock_pkg.sv
package bootlock_pkg;
  localparam int unsigned ID_W     = 8;
  localparam logic [7:0]  MFR_CODE = 8'h1F;
  localparam logic [7:0]  DEV_BOT  = 8'h13;
  localparam logic [7:0]  DEV_TOP  = 8'h12;

  typedef enum logic [1:0] {
    ID_NONE = 2'd0,
    ID_MFR  = 2'd1,
    ID_DEV  = 2'd2,
    ID_LOCK = 2'd3
  } id_sel_e;

  function automatic logic [7:0] dev_code(input bit top);
    return top ? DEV_TOP : DEV_BOT;
  endfunction
endpackage

// File: rtl/bootlock_region.sv
module bootlock_region #(
  parameter int unsigned ADDR_W  = 19,
  parameter int unsigned BOOT_AW = 14,
  parameter bit          TOP_BOOT = 1'b1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              in_boot_o
);
  localparam int unsigned HI_W = ADDR_W - BOOT_AW;

  logic [HI_W-1:0] upper;
  assign upper = addr_i[ADDR_W-1:BOOT_AW];

  generate
    if (TOP_BOOT) begin : g_top
      assign in_boot_o = &upper;
    end else begin : g_bot
      assign in_boot_o = ~|upper;
    end
  endgenerate
endmodule

// File: rtl/bootlock_state.sv
module bootlock_state (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  output logic locked_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     locked_o <= 1'b0;
    else if (set_i) locked_o <= 1'b1;
  end
endmodule

// File: rtl/bootlock_id.sv
module bootlock_id
  import bootlock_pkg::*;
#(
  parameter int unsigned ADDR_W   = 19,
  parameter int unsigned BOOT_AW  = 14,
  parameter bit          TOP_BOOT = 1'b1
) (
  input  logic              id_mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              locked_i,
  output logic [ID_W-1:0]   data_o,
  output logic              hit_o
);
  localparam logic [ADDR_W-1:0] LOW_MASK  = ADDR_W'((64'd1 << BOOT_AW) - 64'd1);
  localparam logic [ADDR_W-1:0] BOOT_BASE = TOP_BOOT ? ~LOW_MASK : '0;
  localparam logic [ADDR_W-1:0] LOCK_LOC  = BOOT_BASE + ADDR_W'(2);

  id_sel_e sel;

  always_comb begin
    sel = ID_NONE;
    if (id_mode_i) begin
      if (addr_i == ADDR_W'(0))      sel = ID_MFR;
      else if (addr_i == ADDR_W'(1)) sel = ID_DEV;
      else if (addr_i == LOCK_LOC)   sel = ID_LOCK;
    end
  end

  always_comb begin
    unique case (sel)
      ID_MFR:  data_o = MFR_CODE;
      ID_DEV:  data_o = dev_code(TOP_BOOT);
      ID_LOCK: data_o = {{(ID_W-1){1'b0}}, locked_i};
      default: data_o = '0;
    endcase
  end

  assign hit_o = (sel != ID_NONE);
endmodule

// File: rtl/bootlock_guard.sv
module bootlock_guard
  import bootlock_pkg::*;
#(
  parameter int unsigned ADDR_W   = 19,
  parameter int unsigned BOOT_AW  = 14,
  parameter bit          TOP_BOOT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_set_i,
  input  logic              prog_req_i,
  input  logic [ADDR_W-1:0] prog_addr_i,
  output logic              prog_ok_o,
  output logic              prog_reject_o,
  input  logic [ADDR_W-1:0] erase_addr_i,
  output logic              erase_keep_o,
  input  logic              id_mode_i,
  input  logic [ADDR_W-1:0] id_addr_i,
  output logic [ID_W-1:0]   id_data_o,
  output logic              id_hit_o,
  output logic              locked_o
);
  // Named internal events for the checker
  logic prog_in_boot;
  logic erase_in_boot;
  logic prog_blocked;

  bootlock_state u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (lock_set_i),
    .locked_o (locked_o)
  );

  bootlock_region #(.ADDR_W(ADDR_W), .BOOT_AW(BOOT_AW), .TOP_BOOT(TOP_BOOT)) u_prog_rgn (
    .addr_i    (prog_addr_i),
    .in_boot_o (prog_in_boot)
  );

  bootlock_region #(.ADDR_W(ADDR_W), .BOOT_AW(BOOT_AW), .TOP_BOOT(TOP_BOOT)) u_erase_rgn (
    .addr_i    (erase_addr_i),
    .in_boot_o (erase_in_boot)
  );

  assign prog_blocked  = locked_o & prog_in_boot;
  assign prog_reject_o = prog_req_i & prog_blocked;
  assign prog_ok_o     = prog_req_i & ~prog_blocked;
  assign erase_keep_o  = locked_o & erase_in_boot;

  bootlock_id #(.ADDR_W(ADDR_W), .BOOT_AW(BOOT_AW), .TOP_BOOT(TOP_BOOT)) u_id (
    .id_mode_i (id_mode_i),
    .addr_i    (id_addr_i),
    .locked_i  (locked_o),
    .data_o    (id_data_o),
    .hit_o     (id_hit_o)
  );
endmodule

// File: rtl/bootlock_guard_chk.sv
module bootlock_guard_chk #(
  parameter int unsigned ADDR_W = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lock_set_i,
  input logic              prog_req_i,
  input logic [ADDR_W-1:0] prog_addr_i,
  input logic              prog_ok_o,
  input logic              prog_reject_o,
  input logic              erase_keep_o,
  input logic              erase_in_boot,
  input logic              prog_in_boot,
  input logic              id_mode_i,
  input logic [7:0]        id_data_o,
  input logic              id_hit_o,
  input logic              locked_o
);
  // R2
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o |=> locked_o);
  // R2
  lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_set_i |=> locked_o);
  // R2
  lock_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_o) |-> $past(lock_set_i));
  // R4
  reject_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_reject_o |-> (prog_req_i && locked_o && prog_in_boot));
  // R4
  ok_reject_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({prog_ok_o, prog_reject_o}) == (prog_req_i ? 1 : 0));
  // R6
  keep_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_keep_o |-> (locked_o && erase_in_boot));
  // R9
  id_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !id_mode_i |-> (id_data_o == 8'h00 && !id_hit_o));
  // R5
  unlocked_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked_o && prog_req_i) |-> prog_ok_o);
  logic unused_addr;
  assign unused_addr = ^prog_addr_i;
endmodule

bind bootlock_guard bootlock_guard_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/bootlock_guard_tb.sv
`timescale 1ns/1ps
module bootlock_guard_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lock_top = 1'b0, lock_bot = 1'b0;
  logic prog_req = 1'b0, id_mode = 1'b0;
  logic [18:0] prog_addr = '0, erase_addr = '0, id_addr = '0;
  logic ok_t, rej_t, keep_t, hit_t, lk_t;
  logic ok_b, rej_b, keep_b, hit_b, lk_b;
  logic [7:0] idd_t, idd_b;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bootlock_guard #(.TOP_BOOT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .lock_set_i(lock_top), .prog_req_i(prog_req),
    .prog_addr_i(prog_addr), .prog_ok_o(ok_t), .prog_reject_o(rej_t),
    .erase_addr_i(erase_addr), .erase_keep_o(keep_t), .id_mode_i(id_mode),
    .id_addr_i(id_addr), .id_data_o(idd_t), .id_hit_o(hit_t), .locked_o(lk_t));

  bootlock_guard #(.TOP_BOOT(1'b0)) u_dut_bot (
    .clk(clk), .rst_n(rst_n), .lock_set_i(lock_bot), .prog_req_i(prog_req),
    .prog_addr_i(prog_addr), .prog_ok_o(ok_b), .prog_reject_o(rej_b),
    .erase_addr_i(erase_addr), .erase_keep_o(keep_b), .id_mode_i(id_mode),
    .id_addr_i(id_addr), .id_data_o(idd_b), .id_hit_o(hit_b), .locked_o(lk_b));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Boot region per R3, restated with magnitude compares
  function automatic bit exp_boot(input int unsigned a, input bit top);
    return top ? (a >= 32'h7C000) : (a < 32'h04000);
  endfunction

  task automatic probe(input int unsigned a, input bit ltop, input bit lbot);
    prog_req = 1'b1; prog_addr = a[18:0]; erase_addr = a[18:0];
    #1;
    // R4 R5: same-cycle program decision
    check("R4_ok_top",  {31'd0, ok_t},  {31'd0, !(ltop && exp_boot(a, 1))});
    check("R4_rej_top", {31'd0, rej_t}, {31'd0,  (ltop && exp_boot(a, 1))});
    check("R4_ok_bot",  {31'd0, ok_b},  {31'd0, !(lbot && exp_boot(a, 0))});
    check("R4_rej_bot", {31'd0, rej_b}, {31'd0,  (lbot && exp_boot(a, 0))});
    // R6 R3: erase keep mask
    check("R6_keep_top", {31'd0, keep_t}, {31'd0, ltop && exp_boot(a, 1)});
    check("R6_keep_bot", {31'd0, keep_b}, {31'd0, lbot && exp_boot(a, 0)});
  endtask

  task automatic sweep(input bit ltop, input bit lbot);
    int unsigned edges[10] = '{0, 1, 2, 32'h3FFF, 32'h4000, 32'h7BFFF,
                                32'h7C000, 32'h7C002, 32'h7FFFE, 32'h7FFFF};
    foreach (edges[i]) probe(edges[i], ltop, lbot);
    for (int unsigned a = 0; a < 32'h80000; a += 251) probe(a, ltop, lbot);
    prog_req = 1'b0; #1;
    // R5: no request, no grant
    check("R5_idle_ok",  {30'd0, ok_t, ok_b},   32'd0);
    check("R5_idle_rej", {30'd0, rej_t, rej_b}, 32'd0);
  endtask

  task automatic id_read(input int unsigned a, input bit ltop, input bit lbot);
    logic [7:0] et, eb; bit ht, hb;
    id_addr = a[18:0]; #1;
    et = 8'h00; eb = 8'h00; ht = 0; hb = 0;
    if (id_mode) begin
      if (a == 0) begin et = 8'h1F; eb = 8'h1F; ht = 1; hb = 1; end
      else if (a == 1) begin et = 8'h12; eb = 8'h13; ht = 1; hb = 1; end
      else begin
        if (a == 32'h7C002) begin et = {7'd0, ltop}; ht = 1; end
        if (a == 2)         begin eb = {7'd0, lbot}; hb = 1; end
      end
    end
    // R7 R8 R9
    check("R7_R8_R9_data_top", {24'd0, idd_t}, {24'd0, et});
    check("R7_R8_R9_data_bot", {24'd0, idd_b}, {24'd0, eb});
    check("R9_hit_top", {31'd0, hit_t}, {31'd0, ht});
    check("R9_hit_bot", {31'd0, hit_b}, {31'd0, hb});
  endtask

  task automatic id_all(input bit ltop, input bit lbot);
    int unsigned pts[9] = '{0, 1, 2, 3, 32'h4002, 32'h7C001, 32'h7C002, 32'h7C003, 32'h7FFFF};
    id_mode = 1'b1;
    foreach (pts[i]) id_read(pts[i], ltop, lbot);
    id_mode = 1'b0;
    foreach (pts[i]) id_read(pts[i], ltop, lbot);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1_locked_top", {31'd0, lk_t}, 32'd0);
    check("R1_locked_bot", {31'd0, lk_b}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1_after_release", {30'd0, lk_t, lk_b}, 32'd0);

    sweep(0, 0);
    id_all(0, 0);

    // R2: lock only the top instance
    @(negedge clk); lock_top = 1'b1;
    @(negedge clk); lock_top = 1'b0;
    check("R2_set_top", {30'd0, lk_t, lk_b}, 32'd2);
    sweep(1, 0);
    id_all(1, 0);

    @(negedge clk); lock_bot = 1'b1;
    @(negedge clk); lock_bot = 1'b0;
    check("R2_set_bot", {30'd0, lk_t, lk_b}, 32'd3);
    sweep(1, 1);
    id_all(1, 1);

    // R2: repeated pulses and idle time leave the lock set
    @(negedge clk); lock_top = 1'b1; lock_bot = 1'b1;
    @(negedge clk); lock_top = 1'b0; lock_bot = 1'b0;
    repeat (50) @(negedge clk);
    check("R2_sticky", {30'd0, lk_t, lk_b}, 32'd3);
    probe(32'h7C000, 1, 1);
    probe(32'h3FFF, 1, 1);

    // R1: reset is the only way out
    rst_n = 1'b0; #1;
    check("R1_reset_clears", {30'd0, lk_t, lk_b}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    probe(32'h7FFFF, 0, 0);
    probe(32'h0, 0, 0);
    id_all(0, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule